// File: doc/BRIEF.md
# Register-or-Memory Operand Address Former

This unit turns the addressing fields of a decoded instruction into an operand location. The operand is either a register, used as it stands, or a 32-bit memory effective address. The inputs are a 2-bit mode field, a 3-bit register/memory selector, an optional scaled-index byte (2-bit scale, 3-bit index, 3-bit base) and a raw 32-bit displacement word. The low byte of that word is used when a short displacement applies.

Register values come in through two 32-bit read ports. One port serves the base register and the other serves the index register, and each select is driven combinationally from the fields. The result is registered, so it appears exactly one clock after a valid request. Along with it the unit reports whether the scaled-index byte was used and what size of displacement the form needed.

Top module: `eag_unit`

## Requirements
- R1: When mode is 3, out_is_reg is 1 and out_reg_num equals the selector. out_addr is 0, out_uses_sib is 0 and out_disp_kind is 0 (none).
- R2: With mode 0 and selector not 4 or 5, the address is the value of the register named by the selector, and out_disp_kind is 0.
- R3: Mode 1 adds the low 8 bits of disp_in, sign-extended to 32 bits, and reports out_disp_kind 1 (byte).
- R4: Mode 2 adds all 32 bits of disp_in and reports out_disp_kind 2 (word).
- R5: With mode 0 and selector 5, no register is added. The address is disp_in alone and out_disp_kind is 2.
- R6: With selector 4 and mode not 3, out_uses_sib is 1 and the address is base register + index register times scale + displacement.
- R7: Scale codes 0, 1, 2 and 3 multiply the index value by 1, 2, 4 and 8.
- R8: An index code of 4 adds no index term, whatever the scale.
- R9: With the scaled-index byte, mode 0 and base code 5, no base register is added. disp_in is added as a 32-bit displacement and out_disp_kind is 2.
- R10: All address sums wrap modulo 2^32.
- R11: Outputs are registered. out_valid is valid_in delayed by one clock, and reset clears out_valid and all result outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request present this cycle |
| mode_in | input | 2 | Addressing mode field |
| rm_in | input | 3 | Register/memory selector |
| sib_scale | input | 2 | Scale code of the scaled-index byte |
| sib_index | input | 3 | Index register code |
| sib_base | input | 3 | Base register code |
| disp_in | input | 32 | Raw displacement word (low byte used for the byte form) |
| rd_base_sel | output | 3 | Register number on the base read port |
| rd_base_data | input | 32 | Value returned by the base read port |
| rd_index_sel | output | 3 | Register number on the index read port |
| rd_index_data | input | 32 | Value returned by the index read port |
| out_valid | output | 1 | Result valid |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_reg_num | output | 3 | Register number for the direct form |
| out_addr | output | 32 | Effective address for memory forms |
| out_uses_sib | output | 1 | Scaled-index byte consumed |
| out_disp_kind | output | 2 | Displacement consumed: 0 none, 1 byte, 2 word |

## Verification
The bench walks every mode and selector pair. For each memory form with a scaled-index byte it also sweeps all scale, index and base codes. Every combination runs with three displacement words.

- A small positive word keeps sums in range.
- A word whose low byte is negative separates sign extension of the byte form from the full-word form.
- A large word forces wrap-around.

Each register returns a distinct value, so any base/index swap, wrong scale, dropped "no index" code or "no base" escape shows up as a wrong address. A gap in valid_in confirms the one-cycle valid delay.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 3;
  localparam int DISP8_W = 8;

  localparam logic [1:0] MODE_REG   = 2'd3;
  localparam logic [1:0] MODE_NODSP = 2'd0;
  localparam logic [1:0] MODE_D8    = 2'd1;
  localparam logic [2:0] RM_ESCAPE  = 3'd4;
  localparam logic [2:0] RM_ABS     = 3'd5;
  localparam logic [2:0] IDX_NONE   = 3'd4;
  localparam logic [2:0] BASE_NONE  = 3'd5;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic       is_reg;
    logic       uses_sib;
    logic       base_en;
    logic       index_en;
    disp_kind_e dk;
  } dec_t;

  function automatic logic [ADDR_W-1:0] sext_byte(input logic [DISP8_W-1:0] b);
    return {{(ADDR_W-DISP8_W){b[DISP8_W-1]}}, b};
  endfunction

  function automatic logic [ADDR_W-1:0] scale_index(input logic [ADDR_W-1:0] v,
                                                    input logic [1:0] code);
    return v << code;
  endfunction
endpackage

// File: rtl/eag_field_decode.sv
module eag_field_decode
  import eag_pkg::*;
(
  input  logic [1:0]       mode_in,
  input  logic [REG_W-1:0] rm_in,
  input  logic [REG_W-1:0] sib_index,
  input  logic [REG_W-1:0] sib_base,
  output dec_t             dec,
  output logic [REG_W-1:0] base_sel,
  output logic [REG_W-1:0] index_sel
);
  logic direct;
  logic escape;
  logic abs_form;
  logic sib_nobase;

  assign direct     = (mode_in == MODE_REG);
  assign escape     = !direct && (rm_in == RM_ESCAPE);
  assign abs_form   = !escape && (mode_in == MODE_NODSP) && (rm_in == RM_ABS);
  assign sib_nobase = escape && (mode_in == MODE_NODSP) && (sib_base == BASE_NONE);

  assign base_sel  = escape ? sib_base : rm_in;
  assign index_sel = sib_index;

  always_comb begin
    dec.is_reg   = direct;
    dec.uses_sib = escape;
    dec.base_en  = !direct && !abs_form && !sib_nobase;
    dec.index_en = escape && (sib_index != IDX_NONE);
    if (direct)                       dec.dk = DISP_NONE;
    else if (abs_form || sib_nobase)  dec.dk = DISP_WORD;
    else if (mode_in == MODE_NODSP)   dec.dk = DISP_NONE;
    else if (mode_in == MODE_D8)      dec.dk = DISP_BYTE;
    else                              dec.dk = DISP_WORD;
  end
endmodule

// File: rtl/eag_addr_sum.sv
module eag_addr_sum
  import eag_pkg::*;
(
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [1:0]        scale_code,
  input  logic [ADDR_W-1:0] disp_raw,
  output logic [ADDR_W-1:0] base_term,
  output logic [ADDR_W-1:0] idx_term,
  output logic [ADDR_W-1:0] disp_term,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    base_term = dec.base_en  ? base_val : '0;
    idx_term  = dec.index_en ? scale_index(index_val, scale_code) : '0;
    case (dec.dk)
      DISP_BYTE: disp_term = sext_byte(disp_raw[DISP8_W-1:0]);
      DISP_WORD: disp_term = disp_raw;
      default:   disp_term = '0;
    endcase
    addr = dec.is_reg ? '0 : (base_term + idx_term + disp_term);
  end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [1:0]        mode_in,
  input  logic [REG_W-1:0]  rm_in,
  input  logic [1:0]        sib_scale,
  input  logic [REG_W-1:0]  sib_index,
  input  logic [REG_W-1:0]  sib_base,
  input  logic [ADDR_W-1:0] disp_in,
  output logic [REG_W-1:0]  rd_base_sel,
  input  logic [ADDR_W-1:0] rd_base_data,
  output logic [REG_W-1:0]  rd_index_sel,
  input  logic [ADDR_W-1:0] rd_index_data,
  output logic              out_valid,
  output logic              out_is_reg,
  output logic [REG_W-1:0]  out_reg_num,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_uses_sib,
  output logic [1:0]        out_disp_kind
);
  dec_t              dec;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] disp_term;
  logic [ADDR_W-1:0] addr_next;

  eag_field_decode u_dec (
    .mode_in   (mode_in),
    .rm_in     (rm_in),
    .sib_index (sib_index),
    .sib_base  (sib_base),
    .dec       (dec),
    .base_sel  (rd_base_sel),
    .index_sel (rd_index_sel)
  );

  eag_addr_sum u_sum (
    .dec        (dec),
    .base_val   (rd_base_data),
    .index_val  (rd_index_data),
    .scale_code (sib_scale),
    .disp_raw   (disp_in),
    .base_term  (base_term),
    .idx_term   (idx_term),
    .disp_term  (disp_term),
    .addr       (addr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_is_reg    <= 1'b0;
      out_reg_num   <= '0;
      out_addr      <= '0;
      out_uses_sib  <= 1'b0;
      out_disp_kind <= 2'd0;
    end else begin
      out_valid <= valid_in;
      if (valid_in) begin
        out_is_reg    <= dec.is_reg;
        out_reg_num   <= dec.is_reg ? rm_in : '0;
        out_addr      <= addr_next;
        out_uses_sib  <= dec.uses_sib;
        out_disp_kind <= dec.dk;
      end
    end
  end

  // R1: a direct register result never carries address, index byte or displacement
  assert_reg_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_reg) |-> (out_addr == '0 && !out_uses_sib && out_disp_kind == 2'd0));

  // R3: byte displacement term is a sign extension of its low byte
  assert_disp_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dec.dk == DISP_BYTE) |->
      (disp_term[ADDR_W-1:DISP8_W] == {(ADDR_W-DISP8_W){disp_in[DISP8_W-1]}}));

  // R7: a scaled index term has as many clear low bits as the scale code
  assert_scale_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dec.index_en) |->
      ((idx_term & ((32'd1 << sib_scale) - 32'd1)) == '0));

  // R8: the "no index" code contributes nothing
  assert_no_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dec.uses_sib && sib_index == IDX_NONE) |-> (idx_term == '0));

  // R9: the "no base" escape drops the base term and takes a full-word displacement
  assert_no_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dec.uses_sib && mode_in == MODE_NODSP && sib_base == BASE_NONE) |->
      (base_term == '0 && disp_term == disp_in));

  // R11: result valid trails the request by exactly one clock
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> out_valid);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !out_valid);
endmodule

// File: tb/eag_unit_test.sv
module eag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [1:0]  mode_in = '0;
  logic [2:0]  rm_in = '0;
  logic [1:0]  sib_scale = '0;
  logic [2:0]  sib_index = '0;
  logic [2:0]  sib_base = '0;
  logic [31:0] disp_in = '0;
  logic [2:0]  rd_base_sel, rd_index_sel;
  logic [31:0] rd_base_data, rd_index_data;
  logic        out_valid, out_is_reg, out_uses_sib;
  logic [2:0]  out_reg_num;
  logic [31:0] out_addr;
  logic [1:0]  out_disp_kind;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eag_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .mode_in(mode_in), .rm_in(rm_in),
    .sib_scale(sib_scale), .sib_index(sib_index), .sib_base(sib_base),
    .disp_in(disp_in),
    .rd_base_sel(rd_base_sel), .rd_base_data(rd_base_data),
    .rd_index_sel(rd_index_sel), .rd_index_data(rd_index_data),
    .out_valid(out_valid), .out_is_reg(out_is_reg), .out_reg_num(out_reg_num),
    .out_addr(out_addr), .out_uses_sib(out_uses_sib), .out_disp_kind(out_disp_kind)
  );

  function automatic logic [31:0] reg_value(input logic [2:0] n);
    logic [31:0] k;
    k = 32'(n) + 32'd1;
    return 32'h9E37_79B9 * k;
  endfunction

  always_comb rd_base_data  = reg_value(rd_base_sel);
  always_comb rd_index_data = reg_value(rd_index_sel);

  task automatic report(input string tag, input logic [31:0] got, input logic [31:0] exp,
                        input string what);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h (mode %0d rm %0d ss %0d ix %0d bs %0d disp %h)",
               tag, what, got, exp, mode_in, rm_in, sib_scale, sib_index, sib_base, disp_in);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [2:0] r, input logic [1:0] s,
                       input logic [2:0] ix, input logic [2:0] bs, input logic [31:0] d);
    logic        e_reg, e_sib;
    logic [2:0]  e_num;
    logic [1:0]  e_dk;
    longint unsigned b, x, dd, wide;
    string tag;
    mode_in = m; rm_in = r; sib_scale = s; sib_index = ix; sib_base = bs; disp_in = d;
    valid_in = 1'b1;
    b = 0; x = 0; dd = 0;
    e_reg = 0; e_num = 0; e_sib = 0; e_dk = 0;
    if (m == 2'd3) begin
      e_reg = 1; e_num = r; tag = "R1";
    end else begin
      e_sib = (r == 3'd4);
      if (m == 2'd1) begin dd = longint'({{24{d[7]}}, d[7:0]}); e_dk = 1; tag = "R3"; end
      else if (m == 2'd2) begin dd = longint'(d); e_dk = 2; tag = "R4"; end
      else tag = "R2";
      if (!e_sib) begin
        if (m == 2'd0 && r == 3'd5) begin dd = longint'(d); e_dk = 2; tag = "R5"; end
        else b = longint'(reg_value(r));
      end else begin
        tag = (s == 2'd0) ? "R6" : "R7";
        if (ix == 3'd4) tag = "R8";
        else x = longint'(reg_value(ix)) * (longint'(1) << s);
        if (m == 2'd0 && bs == 3'd5) begin dd = longint'(d); e_dk = 2; tag = "R9"; end
        else b = longint'(reg_value(bs));
      end
    end
    wide = b + x + dd;
    if (wide > 64'hFFFF_FFFF) tag = "R10";
    @(negedge clk);
    report(tag, 32'(out_valid), 32'd1, "valid");
    report(tag, 32'(out_is_reg), 32'(e_reg), "is_reg");
    report(tag, 32'(out_reg_num), 32'(e_num), "reg_num");
    report(tag, out_addr, wide[31:0], "addr");
    report(tag, 32'(out_uses_sib), 32'(e_sib), "uses_sib");
    report(tag, 32'(out_disp_kind), 32'(e_dk), "disp_kind");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] dl [3];
    dl[0] = 32'h0000_0013;
    dl[1] = 32'hABCD_EF9C;
    dl[2] = 32'hFFFF_FF80;
    repeat (3) @(negedge clk);
    // R11: reset state
    report("R11", 32'(out_valid), 32'd0, "reset valid");
    report("R11", out_addr, 32'd0, "reset addr");
    report("R11", 32'(out_disp_kind), 32'd0, "reset disp_kind");
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 8; r++) begin
        for (int k = 0; k < 3; k++) begin
          if (m != 3 && r == 4) begin
            for (int s = 0; s < 4; s++)
              for (int ix = 0; ix < 8; ix++)
                for (int bs = 0; bs < 8; bs++)
                  apply(2'(m), 3'(r), 2'(s), 3'(ix), 3'(bs), dl[k]);
          end else begin
            apply(2'(m), 3'(r), 2'(k), 3'(k + 1), 3'(7 - k), dl[k]);
          end
        end
      end
    end
    // R11: a gap in requests drops out_valid one clock later
    valid_in = 1'b0;
    @(negedge clk);
    report("R11", 32'(out_valid), 32'd0, "idle valid");
    apply(2'd2, 3'd1, 2'd0, 3'd0, 3'd0, 32'h0000_0100);
    valid_in = 1'b0;
    @(negedge clk);
    report("R11", 32'(out_valid), 32'd0, "idle valid after burst");
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule